// File: doc/BRIEF.md
# CCD Readout Clock Sequencer

This block produces the digital phase clocks that read one frame out of a progressive-scan interline CCD. A frame starts from idle on a start request. A single long vertical-phase-one transfer pulse moves every photodiode charge packet into the vertical registers in one step. The block then runs a loop. Each pass moves one or more lines into horizontal register A with vertical-phase-two pulses, and then shifts the horizontal register out pixel by pixel. A pixel strobe, region flags and row and column indices are produced alongside the shifting.

Readout modes are latched at frame start:
- **Dual-line mode.** The first line is parked in register B before a second line is loaded into A. Both registers then shift out together, so the loop runs half as many times.
- **Binning.** Two vertical transfers are added in register A before one horizontal readout.

A dump request is sampled at the start of each line group. It opens the fast-dump gate during every vertical transfer of that group, and the group then produces no pixel strobes. Every phase width is a cycle count taken from an input. An input of zero selects a nonzero default given by a parameter.

Top module: `ccd_clock_seq`

## Requirements
- R1: From idle, a start request raises `v1_tx_o` for the programmed V1 transfer width. This happens exactly once per frame, and `v2_o` stays low while it is high.
- R2: Each line transfer is one `v2_o` pulse of the programmed V2 width, with `h1a_o` high and `v1_o` low. A frame issues exactly ROW_TOP+ROW_ACT+ROW_BOT such pulses in every mode.
- R3: With binning selected, two V2 pulses feed each horizontal readout, so a frame gives half as many readouts as lines.
- R4: In dual-line mode, after the first load of each group, `h1a_o` goes low and `h1b_o` goes high with `h2_o` low (the park step). Both H1 phases are then high before the next load, and one readout serves both lines. In single-line mode `h1b_o` never rises.
- R5: Each pixel is an `h2_o` high phase of the programmed H width followed by an H1 phase of the same width. `pix_vld_o` is high for one cycle, in the cycle where `h2_o` has just fallen, and `col_o` gives the pixel index, from 0 to NDUM+COL_DL+COL_ACT+COL_DR-1. One readout gives exactly NDUM+COL_DL+COL_ACT+COL_DR strobes.
- R6: `h2_o` is never high together with `h1a_o` or `h1b_o`, and `v1_o` is never high together with `v2_o`.
- R7: With each strobe, the region flags follow the register A layout:
  - `dummy_o` is high for pixel indices below NDUM.
  - Otherwise `dark_o` is high when the row is one of the first ROW_TOP or last ROW_BOT lines, or when the column lies in the first COL_DL or last COL_DR columns after the dummies.
  - `active_o` is high for all other strobes.
  - `row_o` is the index of the last line loaded into register A.
- R8: When `dump_i` is high at the start of a group, `fdg_o` pulses with each V2 pulse of that group, and the group produces no `pix_vld_o`.
- R9: A width input of zero selects the parameter default for that phase: DEF_V1, DEF_V2, DEF_GAP or DEF_H.
- R10: A start request while `busy_o` is high does not start a new transfer pulse. `busy_o` falls after the frame ends.
- R11: After reset the outputs are at their idle levels: `v1_o` and `h1a_o` high, and every other strobe and phase low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Frame start request |
| dual_i | input | 1 | Dual-line readout select, latched at start |
| bin_i | input | 1 | Two-to-one binning select, latched at start |
| dump_i | input | 1 | Dump request, sampled per line group |
| v1_w_i | input | TW | V1 transfer width in cycles (0 = default) |
| v2_w_i | input | TW | V2 pulse width and park width (0 = default) |
| gap_w_i | input | TW | Gap and guard width (0 = default) |
| h_w_i | input | TW | Horizontal half-pixel width (0 = default) |
| v1_o | output | 1 | Vertical phase one |
| v1_tx_o | output | 1 | V1 at photodiode transfer level |
| v2_o | output | 1 | Vertical phase two |
| h1a_o | output | 1 | Horizontal phase one, register A |
| h1b_o | output | 1 | Horizontal phase one, register B |
| h2_o | output | 1 | Horizontal phase two |
| fdg_o | output | 1 | Fast-dump gate |
| pix_vld_o | output | 1 | Pixel strobe |
| dummy_o | output | 1 | Strobe is a dummy cell |
| dark_o | output | 1 | Strobe is a dark reference pixel |
| active_o | output | 1 | Strobe is an active pixel |
| row_o | output | RW | Last line index loaded into register A |
| col_o | output | CW | Pixel index within the readout |
| busy_o | output | 1 | Frame in progress |

## Verification
The hardest case to reach is the park hand-off with binning on top of dual-line mode. Four vertical transfers have to line up, with a park step between the second and third, before one shared readout. Errors in the parity and half tracking show up only in that combination. The bench drives the dual, binning and dual-binning modes as separate frames on a reduced array geometry. It predicts the park count, the strobe count and the active strobe count from the row layout. A start pulse in the middle of a frame and a frame with a zero width on every timing input cover the ignore and default rules.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

    localparam int TW = 8;

    typedef enum logic [3:0] {
        S_IDLE, S_PDX, S_PDG, S_V2HI, S_V2LO,
        S_PARK, S_JOIN, S_RDH2, S_RDH1, S_END
    } seq_st_t;

    typedef struct packed {
        logic          dual;
        logic          bin;
        logic [TW-1:0] v2w;
        logic [TW-1:0] gw;
        logic [TW-1:0] hw;
    } seq_cfg_t;

    function automatic logic [TW-1:0] pick_w(input logic [TW-1:0] v, input logic [TW-1:0] d);
        return (v == '0) ? d : v;
    endfunction

endpackage

// File: rtl/ccd_phase_cnt.sv
module ccd_phase_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld_i,
    input  logic [W-1:0] len_i,
    output logic         done_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)              cnt_q <= '0;
        else if (ld_i)        cnt_q <= len_i - W'(1);
        else if (cnt_q != '0) cnt_q <= cnt_q - W'(1);
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/ccd_region.sv
module ccd_region #(
    parameter int ROW_TOP = 8,
    parameter int ROW_ACT = 484,
    parameter int ROW_BOT = 4,
    parameter int NDUM    = 10,
    parameter int COL_DL  = 24,
    parameter int COL_ACT = 648,
    parameter int COL_DR  = 8,
    parameter int RW      = 9,
    parameter int CW      = 10
) (
    input  logic [RW-1:0] row_i,
    input  logic [CW-1:0] col_i,
    output logic          dummy_o,
    output logic          dark_o,
    output logic          active_o
);
    logic [CW-1:0] c_rel;
    logic          col_dark, row_dark;

    always_comb begin
        c_rel    = col_i - CW'(NDUM);
        dummy_o  = col_i < CW'(NDUM);
        col_dark = (c_rel < CW'(COL_DL)) || (c_rel >= CW'(COL_DL + COL_ACT));
        row_dark = (row_i < RW'(ROW_TOP)) || (row_i >= RW'(ROW_TOP + ROW_ACT));
        dark_o   = !dummy_o && (col_dark || row_dark);
        active_o = !dummy_o && !col_dark && !row_dark;
    end
endmodule

// File: rtl/ccd_clock_seq.sv
module ccd_clock_seq
    import ccd_seq_pkg::*;
#(
    parameter int ROW_TOP = 8,
    parameter int ROW_ACT = 484,
    parameter int ROW_BOT = 4,
    parameter int NDUM    = 10,
    parameter int COL_DL  = 24,
    parameter int COL_ACT = 648,
    parameter int COL_DR  = 8,
    parameter int DEF_V1  = 6,
    parameter int DEF_V2  = 4,
    parameter int DEF_GAP = 2,
    parameter int DEF_H   = 2,
    localparam int NROW   = ROW_TOP + ROW_ACT + ROW_BOT,
    localparam int NH     = NDUM + COL_DL + COL_ACT + COL_DR,
    localparam int RW     = $clog2(NROW + 1),
    localparam int CW     = $clog2(NH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          dual_i,
    input  logic          bin_i,
    input  logic          dump_i,
    input  logic [TW-1:0] v1_w_i,
    input  logic [TW-1:0] v2_w_i,
    input  logic [TW-1:0] gap_w_i,
    input  logic [TW-1:0] h_w_i,
    output logic          v1_o,
    output logic          v1_tx_o,
    output logic          v2_o,
    output logic          h1a_o,
    output logic          h1b_o,
    output logic          h2_o,
    output logic          fdg_o,
    output logic          pix_vld_o,
    output logic          dummy_o,
    output logic          dark_o,
    output logic          active_o,
    output logic [RW-1:0] row_o,
    output logic [CW-1:0] col_o,
    output logic          busy_o
);
    seq_st_t       st_q, nxt;
    seq_cfg_t      cfg_q;
    logic [TW-1:0] len;
    logic          adv, ld, grp;
    logic          dump_q, half_q, odd_q, pv_q;
    logic [RW-1:0] vrow_q, row_q;
    logic [CW-1:0] col_q;
    logic          rg_dum, rg_dark, rg_act;
    logic          last_line;

    ccd_phase_cnt #(.W(TW)) u_tmr (
        .clk(clk), .rst(rst), .ld_i(ld), .len_i(len), .done_o(adv)
    );

    ccd_region #(
        .ROW_TOP(ROW_TOP), .ROW_ACT(ROW_ACT), .ROW_BOT(ROW_BOT), .NDUM(NDUM),
        .COL_DL(COL_DL), .COL_ACT(COL_ACT), .COL_DR(COL_DR), .RW(RW), .CW(CW)
    ) u_reg (
        .row_i(row_q), .col_i(col_q),
        .dummy_o(rg_dum), .dark_o(rg_dark), .active_o(rg_act)
    );

    assign last_line = (vrow_q == RW'(NROW));

    always_comb begin
        nxt = st_q;
        len = TW'(1);
        grp = 1'b0;
        case (st_q)
            S_IDLE: if (start_i) begin nxt = S_PDX; len = pick_w(v1_w_i, TW'(DEF_V1)); end
            S_PDX:  if (adv) begin nxt = S_PDG; len = cfg_q.gw; end
            S_PDG:  if (adv) begin nxt = S_V2HI; len = cfg_q.v2w; grp = 1'b1; end
            S_V2HI: if (adv) begin nxt = S_V2LO; len = cfg_q.gw; end
            S_V2LO: if (adv) begin
                if (cfg_q.bin && !odd_q)        begin nxt = S_V2HI; len = cfg_q.v2w; end
                else if (cfg_q.dual && !half_q) begin nxt = S_PARK; len = cfg_q.v2w; end
                else if (!dump_q)               begin nxt = S_RDH2; len = cfg_q.hw; end
                else if (last_line)             begin nxt = S_END;  len = cfg_q.gw; end
                else begin nxt = S_V2HI; len = cfg_q.v2w; grp = 1'b1; end
            end
            S_PARK: if (adv) begin nxt = S_JOIN; len = cfg_q.gw; end
            S_JOIN: if (adv) begin nxt = S_V2HI; len = cfg_q.v2w; end
            S_RDH2: if (adv) begin nxt = S_RDH1; len = cfg_q.hw; end
            S_RDH1: if (adv) begin
                if (col_q != CW'(NH - 1)) begin nxt = S_RDH2; len = cfg_q.hw; end
                else if (last_line)       begin nxt = S_END;  len = cfg_q.gw; end
                else begin nxt = S_V2HI; len = cfg_q.v2w; grp = 1'b1; end
            end
            S_END:  if (adv) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
        ld = (nxt != st_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= S_IDLE; cfg_q <= '0; dump_q <= 1'b0; half_q <= 1'b0; odd_q <= 1'b0;
            pv_q <= 1'b0; vrow_q <= '0; row_q <= '0; col_q <= '0;
        end else begin
            st_q <= nxt;
            pv_q <= (st_q == S_RDH2) && adv;
            if (st_q == S_IDLE && start_i) begin
                cfg_q.dual <= dual_i;
                cfg_q.bin  <= bin_i;
                cfg_q.v2w  <= pick_w(v2_w_i, TW'(DEF_V2));
                cfg_q.gw   <= pick_w(gap_w_i, TW'(DEF_GAP));
                cfg_q.hw   <= pick_w(h_w_i, TW'(DEF_H));
                vrow_q     <= '0;
                odd_q      <= 1'b0;
            end
            if (ld && grp) begin
                dump_q <= dump_i;
                half_q <= 1'b0;
            end
            if (ld && nxt == S_PARK) half_q <= 1'b1;
            if (st_q == S_V2HI && adv) begin
                row_q  <= vrow_q;
                vrow_q <= vrow_q + RW'(1);
            end
            if (st_q == S_V2LO && adv && cfg_q.bin) odd_q <= !odd_q;
            if (st_q == S_V2LO && nxt == S_RDH2) col_q <= '0;
            else if (st_q == S_RDH1 && adv)      col_q <= col_q + CW'(1);
        end
    end

    assign v1_tx_o   = (st_q == S_PDX);
    assign v2_o      = (st_q == S_V2HI);
    assign v1_o      = !v2_o;
    assign h2_o      = (st_q == S_RDH2);
    assign h1a_o     = (st_q != S_PARK) && !h2_o;
    assign h1b_o     = (st_q == S_PARK) || (st_q == S_JOIN) || (cfg_q.dual && st_q == S_RDH1);
    assign fdg_o     = v2_o && dump_q;
    assign pix_vld_o = pv_q;
    assign dummy_o   = pv_q && rg_dum;
    assign dark_o    = pv_q && rg_dark;
    assign active_o  = pv_q && rg_act;
    assign row_o     = row_q;
    assign col_o     = col_q;
    assign busy_o    = (st_q != S_IDLE);

    p_tx_v2_low_r1: assert property (@(posedge clk) disable iff (rst)
        v1_tx_o |-> !v2_o);
    p_xfer_h1a_r2: assert property (@(posedge clk) disable iff (rst)
        v2_o |-> (h1a_o && !h2_o));
    p_park_h2_low_r4: assert property (@(posedge clk) disable iff (rst)
        (h1b_o && !h1a_o) |-> (!h2_o && cfg_q.dual));
    p_strobe_h2_fall_r5: assert property (@(posedge clk) disable iff (rst)
        pix_vld_o |-> (!h2_o && $past(h2_o)));
    p_col_range_r5: assert property (@(posedge clk) disable iff (rst)
        pix_vld_o |-> (col_o < CW'(NH)));
    p_h_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(h2_o && (h1a_o || h1b_o)));
    p_one_flag_r7: assert property (@(posedge clk) disable iff (rst)
        pix_vld_o |-> $onehot({dummy_o, dark_o, active_o}));
    p_dump_window_r8: assert property (@(posedge clk) disable iff (rst)
        fdg_o |-> v2_o);
    p_no_dump_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        pix_vld_o |-> !dump_q);
    p_no_restart_r10: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> !$rose(v1_tx_o));
endmodule

// File: tb/test_ccd_clock_seq.sv
module test_ccd_clock_seq;
    logic       clk = 1'b0;
    logic       rst;
    logic       start_i, dual_i, bin_i, dump_i;
    logic [7:0] v1_w_i, v2_w_i, gap_w_i, h_w_i;
    logic       v1_o, v1_tx_o, v2_o, h1a_o, h1b_o, h2_o, fdg_o;
    logic       pix_vld_o, dummy_o, dark_o, active_o, busy_o;
    logic [3:0] row_o;
    logic [3:0] col_o;

    int checks = 0, errors = 0;
    int n_pix, n_dum, n_dark, n_act, n_v2, n_pd, n_fdg, n_park, n_h1b, n_ovl, n_align, n_wbad;
    int row_max, col_max, r_v2, r_h2, r_tx, e_v2, e_h, e_v1;
    logic p_v2, p_h2, p_tx, p_fdg, p_park;

    always #2 clk = ~clk;

    ccd_clock_seq #(
        .ROW_TOP(2), .ROW_ACT(4), .ROW_BOT(2), .NDUM(2),
        .COL_DL(2), .COL_ACT(4), .COL_DR(1)
    ) i_ccd_clock_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .dual_i(dual_i), .bin_i(bin_i),
        .dump_i(dump_i), .v1_w_i(v1_w_i), .v2_w_i(v2_w_i), .gap_w_i(gap_w_i),
        .h_w_i(h_w_i), .v1_o(v1_o), .v1_tx_o(v1_tx_o), .v2_o(v2_o), .h1a_o(h1a_o),
        .h1b_o(h1b_o), .h2_o(h2_o), .fdg_o(fdg_o), .pix_vld_o(pix_vld_o),
        .dummy_o(dummy_o), .dark_o(dark_o), .active_o(active_o), .row_o(row_o),
        .col_o(col_o), .busy_o(busy_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic mon_clear();
        n_pix = 0; n_dum = 0; n_dark = 0; n_act = 0; n_v2 = 0; n_pd = 0; n_fdg = 0;
        n_park = 0; n_h1b = 0; n_ovl = 0; n_align = 0; n_wbad = 0;
        row_max = 0; col_max = 0; r_v2 = 0; r_h2 = 0; r_tx = 0;
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (pix_vld_o) begin
                n_pix++;
                if (dummy_o)  n_dum++;
                if (dark_o)   n_dark++;
                if (active_o) n_act++;
                if (!(p_h2 && !h2_o)) n_align++;
                if (int'(row_o) > row_max) row_max = int'(row_o);
                if (int'(col_o) > col_max) col_max = int'(col_o);
            end
            if (v2_o && !p_v2)     n_v2++;
            if (v1_tx_o && !p_tx)  n_pd++;
            if (fdg_o && !p_fdg)   n_fdg++;
            if ((h1b_o && !h1a_o && !h2_o) && !p_park) n_park++;
            if (h1b_o) n_h1b++;
            if ((h2_o && (h1a_o || h1b_o)) || (v1_o && v2_o)) n_ovl++;
            if (v2_o) r_v2++; else if (p_v2) begin if (r_v2 != e_v2) n_wbad++; r_v2 = 0; end
            if (h2_o) r_h2++; else if (p_h2) begin if (r_h2 != e_h) n_wbad++; r_h2 = 0; end
            if (v1_tx_o) r_tx++; else if (p_tx) begin if (r_tx != e_v1) n_wbad++; r_tx = 0; end
        end
        p_v2 = v2_o; p_h2 = h2_o; p_tx = v1_tx_o; p_fdg = fdg_o;
        p_park = h1b_o && !h1a_o && !h2_o;
    end

    task automatic run_frame(input logic d, input logic b, input logic dp,
                             input int w1, input int w2, input int wg, input int wh);
        dual_i = d; bin_i = b; dump_i = dp;
        v1_w_i = 8'(w1); v2_w_i = 8'(w2); gap_w_i = 8'(wg); h_w_i = 8'(wh);
        e_v1 = (w1 == 0) ? 6 : w1; e_v2 = (w2 == 0) ? 4 : w2; e_h = (wh == 0) ? 2 : wh;
        mon_clear();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        while (busy_o) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R11 v1", int'(v1_o), 1);   chk("R11 h1a", int'(h1a_o), 1);
        chk("R11 v2", int'(v2_o), 0);   chk("R11 h1b", int'(h1b_o), 0);
        chk("R11 h2", int'(h2_o), 0);   chk("R11 fdg", int'(fdg_o), 0);
        chk("R11 pix", int'(pix_vld_o), 0); chk("R11 busy", int'(busy_o), 0);
    endtask

    task automatic t_single();
        run_frame(0, 0, 0, 3, 2, 1, 1);
        chk("R1 transfer pulses", n_pd, 1);
        chk("R2 v2 pulses", n_v2, 8);
        chk("R5 strobes", n_pix, 72);
        chk("R5 col max", col_max, 8);
        chk("R5 strobe alignment errors", n_align, 0);
        chk("R1 R2 R5 width errors", n_wbad, 0);
        chk("R6 overlap cycles", n_ovl, 0);
        chk("R4 h1b cycles single", n_h1b, 0);
        chk("R7 dummy", n_dum, 16);
        chk("R7 active", n_act, 16);
        chk("R7 dark", n_dark, 40);
        chk("R7 row max", row_max, 7);
        chk("R10 busy after frame", int'(busy_o), 0);
    endtask

    task automatic t_dual();
        run_frame(1, 0, 0, 2, 3, 2, 2);
        chk("R4 strobes dual", n_pix, 36);
        chk("R4 parks dual", n_park, 4);
        chk("R2 v2 pulses dual", n_v2, 8);
        chk("R7 active dual", n_act, 8);
        chk("R6 overlap dual", n_ovl, 0);
        chk("R4 width errors dual", n_wbad, 0);
    endtask

    task automatic t_bin();
        run_frame(0, 1, 0, 2, 2, 1, 1);
        chk("R3 strobes bin", n_pix, 36);
        chk("R3 v2 pulses bin", n_v2, 8);
        chk("R3 active bin", n_act, 8);
        chk("R3 parks bin", n_park, 0);
    endtask

    task automatic t_dualbin();
        run_frame(1, 1, 0, 2, 2, 1, 1);
        chk("R3 R4 strobes dual bin", n_pix, 18);
        chk("R3 R4 parks dual bin", n_park, 2);
        chk("R3 R4 v2 dual bin", n_v2, 8);
        chk("R7 active dual bin", n_act, 4);
        chk("R7 dark dual bin", n_dark, 10);
    endtask

    task automatic t_dump();
        run_frame(0, 0, 1, 2, 2, 1, 1);
        chk("R8 strobes dumped", n_pix, 0);
        chk("R8 dump pulses", n_fdg, 8);
        chk("R8 v2 pulses dumped", n_v2, 8);
    endtask

    task automatic t_zero();
        run_frame(0, 0, 0, 0, 0, 0, 0);
        chk("R9 default width errors", n_wbad, 0);
        chk("R9 strobes", n_pix, 72);
    endtask

    task automatic t_restart();
        dual_i = 0; bin_i = 0; dump_i = 0;
        v1_w_i = 8'd2; v2_w_i = 8'd2; gap_w_i = 8'd1; h_w_i = 8'd1;
        e_v1 = 2; e_v2 = 2; e_h = 1;
        mon_clear();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        repeat (40) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        while (busy_o) @(negedge clk);
        repeat (5) @(negedge clk);
        chk("R10 transfer pulses", n_pd, 1);
        chk("R10 strobes", n_pix, 72);
        chk("R10 busy low", int'(busy_o), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; start_i = 0; dual_i = 0; bin_i = 0; dump_i = 0;
        v1_w_i = 0; v2_w_i = 0; gap_w_i = 0; h_w_i = 0;
        mon_clear(); e_v1 = 6; e_v2 = 4; e_h = 2;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_dual();
        t_bin();
        t_dualbin();
        t_dump();
        t_zero();
        t_restart();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule